// File: doc/BRIEF.md
# Packed Calendar Clock with BCD Year

This block keeps wall-clock time as a calendar rather than as a running count of seconds. One 32-bit word holds the seconds, minutes, hours, weekday, day of month and month in fixed bit positions. A separate 16-bit word holds the year as four BCD digits, with the century in the upper byte. An external one-pulse-per-second strobe (`tick_i`) advances the calendar by one second. Carries ripple through every field, and the day-of-month rollover follows month lengths and the Gregorian leap-year rule.

Software or a neighbouring block sets the time with load strobes. It sets an alarm point with a second pair of strobes that share the same data buses. Each tick compares the advanced calendar, year included, against that alarm point. A full match raises a sticky alarm flag, which stays high until it is cleared explicitly. All outputs come straight from registers.

Top module: `cal_clock`

## Requirements
- R1: After a synchronous reset, `time_o` reads 0x021E0000, which is 1 January at 00:00:00 with weekday 7 (Saturday). `year_o` reads 0x2000 and `alarm_o` reads 0.
- R2: The time word fields sit at these positions: seconds [5:0], minutes [11:6], hours [16:12], weekday [19:17], day of month [24:20], month [28:25]. Bits [31:29] are spare bits that keep whatever was loaded. Pulsing `time_load_i` makes `time_o` equal `time_wdata_i` on the next cycle. Pulsing `year_load_i` does the same for `year_o` with `year_wdata_i`. In any cycle where either load strobe is high, `tick_i` is ignored.
- R3: On each accepted tick the seconds advance. Seconds wrap 59→0 and carry into minutes, minutes wrap 59→0 and carry into hours, and hours wrap 23→0 and carry into the date. Without a tick, the time and year hold.
- R4: When the hours wrap, the weekday advances by one, wrapping from 7 to 1 (1 = Sunday).
- R5: The day of month wraps to 1 after day 30 in months 4, 6, 9 and 11, and after day 31 in months 1, 3, 5, 7, 8, 10 and 12. Each wrap carries into the month. The month wraps from 12 to 1 and carries into the year.
- R6: February wraps after day 29 when the year is a multiple of 4 but not of 100, or a multiple of 400. In every other year it wraps after day 28.
- R7: A year carry increments the four-digit BCD year with a decimal carry between digits. The low byte carries into the century byte (0x2099→0x2100), and 0x9999 wraps to 0x0000.
- R8: On an accepted tick, the alarm flag sets if bits [28:0] of the advanced time equal the stored alarm time and the advanced year equals the stored alarm year. The flag then stays set until `alarm_clr_i` is pulsed. A set in the same cycle as a clear wins.
- R9: `match_time_load_i` and `match_year_load_i` store the alarm time and alarm year from the shared data buses. Loading them leaves `time_o` and `year_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-second advance strobe |
| time_load_i | input | 1 | Load the time word from `time_wdata_i` |
| year_load_i | input | 1 | Load the year from `year_wdata_i` |
| match_time_load_i | input | 1 | Load the alarm time from `time_wdata_i` |
| match_year_load_i | input | 1 | Load the alarm year from `year_wdata_i` |
| alarm_clr_i | input | 1 | Clear the alarm flag |
| time_wdata_i | input | 32 | Packed time data for loads |
| year_wdata_i | input | 16 | BCD year data for loads |
| time_o | output | 32 | Current packed time |
| year_o | output | 16 | Current BCD year |
| alarm_o | output | 1 | Sticky alarm flag |

## Verification
The bench targets the rollovers that sit at the edges of the calendar:
- February 28 in 1900, 2000, 2023 and 2024. A design with a wrong leap rule would show 29 February in 1900 or 2023, or would skip it in 2000 or 2024.
- The last day of a 30-day month and of a 31-day month. A wrong month table would land on day 31 of April or jump early out of January.
- New Year in 1999, 2099 and 9999. A binary increment in place of a BCD increment would show 0x209A or fail to wrap to 0x0000.
- The weekday at midnight on a Saturday, which a faulty wrap would step to 0 or 8.
- The alarm against a year mismatch, its sticky hold, a clear, and a clear that collides with a set.
- A load that collides with a tick, which must not advance.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int TIME_W      = 32;
  localparam int YEAR_DIGITS = 4;
  localparam int YEAR_W      = 4 * YEAR_DIGITS;
  localparam int FIELD_TOP   = 28;
  localparam int MATCH_W     = FIELD_TOP + 1;

  typedef struct packed {
    logic [2:0] spare;
    logic [3:0] mon;
    logic [4:0] mday;
    logic [2:0] wday;
    logic [4:0] hour;
    logic [5:0] min;
    logic [5:0] sec;
  } cal_time_t;

  localparam logic [TIME_W-1:0] RST_TIME = 32'h021E_0000;
  localparam logic [YEAR_W-1:0] RST_YEAR = 16'h2000;
endpackage

// File: rtl/cal_bcd_inc.sv
module cal_bcd_inc #(
  parameter int DIGITS = 4,
  localparam int W = 4 * DIGITS
) (
  input  logic [W-1:0] val_i,
  output logic [W-1:0] val_o
);
  logic [DIGITS:0] carry;
  assign carry[0] = 1'b1;

  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    logic [3:0] dig;
    logic       top;
    assign dig = val_i[4*i +: 4];
    assign top = (dig >= 4'd9);
    assign val_o[4*i +: 4] = carry[i] ? (top ? 4'd0 : dig + 4'd1) : dig;
    assign carry[i+1] = carry[i] & top;
  end
endmodule

// File: rtl/cal_month_len.sv
module cal_month_len
  import cal_pkg::*;
(
  input  logic [3:0]        mon_i,
  input  logic [YEAR_W-1:0] year_i,
  output logic [4:0]        days_o
);
  // Divisible by 4 test for a two-digit BCD value.
  function automatic logic bcd_div4(input logic [7:0] b);
    logic [3:0] ones;
    ones = b[3:0];
    if (b[4]) return (ones == 4'd2) || (ones == 4'd6);
    else      return (ones == 4'd0) || (ones == 4'd4) || (ones == 4'd8);
  endfunction

  logic [7:0] yr_lo, yr_hi;
  logic       leap;
  assign yr_lo = year_i[7:0];
  assign yr_hi = year_i[YEAR_W-1:8];
  // Whole centuries follow the century digits (x400 rule), others the low digits.
  assign leap  = (yr_lo != 8'h00) ? bcd_div4(yr_lo) : bcd_div4(yr_hi);

  always_comb begin
    case (mon_i)
      4'd2:                     days_o = leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:  days_o = 5'd30;
      default:                  days_o = 5'd31;
    endcase
  end
endmodule

// File: rtl/cal_time_next.sv
module cal_time_next
  import cal_pkg::*;
(
  input  cal_time_t         cur_i,
  input  logic [YEAR_W-1:0] year_i,
  output cal_time_t         nxt_o,
  output logic [YEAR_W-1:0] year_nxt_o
);
  logic [4:0]        dim;
  logic [YEAR_W-1:0] year_inc;
  logic              w_sec, w_min, w_hour, w_day, w_mon;

  cal_month_len u_mlen (.mon_i(cur_i.mon), .year_i(year_i), .days_o(dim));
  cal_bcd_inc #(.DIGITS(YEAR_DIGITS)) u_yinc (.val_i(year_i), .val_o(year_inc));

  assign w_sec  = (cur_i.sec  >= 6'd59);
  assign w_min  = w_sec  & (cur_i.min  >= 6'd59);
  assign w_hour = w_min  & (cur_i.hour >= 5'd23);
  assign w_day  = w_hour & (cur_i.mday >= dim);
  assign w_mon  = w_day  & (cur_i.mon  >= 4'd12);

  always_comb begin
    nxt_o       = cur_i;
    nxt_o.sec   = w_sec  ? 6'd0 : cur_i.sec + 6'd1;
    if (w_sec)  nxt_o.min  = w_min  ? 6'd0 : cur_i.min + 6'd1;
    if (w_min)  nxt_o.hour = w_hour ? 5'd0 : cur_i.hour + 5'd1;
    if (w_hour) begin
      nxt_o.wday = (cur_i.wday >= 3'd7) ? 3'd1 : cur_i.wday + 3'd1;
      nxt_o.mday = w_day ? 5'd1 : cur_i.mday + 5'd1;
    end
    if (w_day)  nxt_o.mon  = w_mon ? 4'd1 : cur_i.mon + 4'd1;
    year_nxt_o  = w_mon ? year_inc : year_i;
  end
endmodule

// File: rtl/cal_clock.sv
module cal_clock
  import cal_pkg::*;
#(
  parameter logic [TIME_W-1:0] RESET_TIME = RST_TIME,
  parameter logic [YEAR_W-1:0] RESET_YEAR = RST_YEAR
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              time_load_i,
  input  logic              year_load_i,
  input  logic              match_time_load_i,
  input  logic              match_year_load_i,
  input  logic              alarm_clr_i,
  input  logic [TIME_W-1:0] time_wdata_i,
  input  logic [YEAR_W-1:0] year_wdata_i,
  output logic [TIME_W-1:0] time_o,
  output logic [YEAR_W-1:0] year_o,
  output logic              alarm_o
);
  cal_time_t          time_q, time_nxt;
  logic [YEAR_W-1:0]  year_q, year_nxt;
  logic [MATCH_W-1:0] mtime_q;
  logic [YEAR_W-1:0]  myear_q;
  logic               alarm_q, adv, hit;

  cal_time_next u_next (
    .cur_i(time_q), .year_i(year_q), .nxt_o(time_nxt), .year_nxt_o(year_nxt)
  );

  assign adv = tick_i & ~time_load_i & ~year_load_i;
  assign hit = adv & (time_nxt[FIELD_TOP:0] == mtime_q) & (year_nxt == myear_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      time_q  <= cal_time_t'(RESET_TIME);
      year_q  <= RESET_YEAR;
      mtime_q <= '0;
      myear_q <= '0;
      alarm_q <= 1'b0;
    end else begin
      if (time_load_i)       time_q  <= cal_time_t'(time_wdata_i);
      else if (adv)          time_q  <= time_nxt;
      if (year_load_i)       year_q  <= year_wdata_i;
      else if (adv)          year_q  <= year_nxt;
      if (match_time_load_i) mtime_q <= time_wdata_i[FIELD_TOP:0];
      if (match_year_load_i) myear_q <= year_wdata_i;
      if (hit)               alarm_q <= 1'b1;
      else if (alarm_clr_i)  alarm_q <= 1'b0;
    end
  end

  assign time_o  = time_q;
  assign year_o  = year_q;
  assign alarm_o = alarm_q;

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    time_load_i |=> (time_o == $past(time_wdata_i)));
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !time_load_i && !year_load_i) |=> ($stable(time_o) && $stable(year_o)));
  assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (adv && time_q.sec == 6'd59) |=> (time_q.sec == 6'd0));
  assert_wday_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (adv && time_q.sec == 6'd59 && time_q.min == 6'd59 && time_q.hour == 5'd23
     && time_q.wday == 3'd7) |=> (time_q.wday == 3'd1));
  assert_alarm_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (alarm_o && !alarm_clr_i) |=> alarm_o);
  assert_alarm_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (alarm_clr_i && !adv) |=> !alarm_o);
  assert_match_no_time_R9: assert property (@(posedge clk) disable iff (rst)
    (match_time_load_i && !time_load_i && !tick_i) |=> $stable(time_o));
endmodule

// File: tb/cal_clock_tb.sv
module cal_clock_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic tick_i = 0, time_load_i = 0, year_load_i = 0;
  logic match_time_load_i = 0, match_year_load_i = 0, alarm_clr_i = 0;
  logic [31:0] time_wdata_i = '0;
  logic [15:0] year_wdata_i = '0;
  logic [31:0] time_o;
  logic [15:0] year_o;
  logic        alarm_o;

  always #4 clk = ~clk;

  cal_clock u_dut (.*);

  // Reference model (binary fields, decimal year)
  int s, mi, h, wd, md, mo, yr, sp;
  logic [28:0] m_time;
  logic [15:0] m_year;
  logic        alarm_m;
  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] q_t[$];
  logic [15:0] q_y[$];
  logic        q_a[$];
  string       q_tag[$];

  function automatic logic [31:0] pack();
    return (32'(sp) << 29) | (32'(mo) << 25) | (32'(md) << 20) | (32'(wd) << 17)
         | (32'(h) << 12) | (32'(mi) << 6) | 32'(s);
  endfunction

  function automatic logic [15:0] bcd(int y);
    return 16'(((y / 1000) << 12) | (((y / 100) % 10) << 8) | (((y / 10) % 10) << 4) | (y % 10));
  endfunction

  function automatic int mdays(int m, int y);
    if (m == 2) return (((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0)) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic adv_model();
    s++;
    if (s > 59) begin
      s = 0; mi++;
      if (mi > 59) begin
        mi = 0; h++;
        if (h > 23) begin
          h = 0; wd = (wd == 7) ? 1 : wd + 1; md++;
          if (md > mdays(mo, yr)) begin
            md = 1; mo++;
            if (mo > 12) begin mo = 1; yr = (yr + 1) % 10000; end
          end
        end
      end
    end
  endtask

  task automatic push(string tag);
    q_t.push_back(pack()); q_y.push_back(bcd(yr)); q_a.push_back(alarm_m); q_tag.push_back(tag);
  endtask

  task automatic set_cal(int ss, int mm, int hh, int w, int d, int m, int y);
    s = ss; mi = mm; h = hh; wd = w; md = d; mo = m; yr = y;
    time_wdata_i = pack(); year_wdata_i = bcd(yr);
    time_load_i = 1; year_load_i = 1;
  endtask

  task automatic step(bit tk, bit clr, string tag);
    bit adv;
    adv = tk && !time_load_i && !year_load_i;
    tick_i = tk; alarm_clr_i = clr;
    @(posedge clk); #2;
    tick_i = 0; alarm_clr_i = 0; time_load_i = 0; year_load_i = 0;
    match_time_load_i = 0; match_year_load_i = 0;
    if (adv) begin
      adv_model();
      if (pack()[28:0] == m_time && bcd(yr) == m_year) alarm_m = 1;
      else if (clr) alarm_m = 0;
    end else if (clr) alarm_m = 0;
    push(tag);
  endtask

  // Monitor: compares at the falling edge
  always @(negedge clk) begin
    if (!rst && q_t.size() > 0) begin
      logic [31:0] et; logic [15:0] ey; logic ea; string tg;
      et = q_t.pop_front(); ey = q_y.pop_front(); ea = q_a.pop_front(); tg = q_tag.pop_front();
      checks++;
      if (time_o !== et || year_o !== ey || alarm_o !== ea) begin
        fails++;
        $display("FAIL %s: time %h exp %h, year %h exp %h, alarm %b exp %b",
                 tg, time_o, et, year_o, ey, alarm_o, ea);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    s = 0; mi = 0; h = 0; wd = 7; md = 1; mo = 1; yr = 2000; sp = 0;
    m_time = '0; m_year = '0; alarm_m = 0;
    repeat (3) @(posedge clk);
    #2 rst = 0;
    push("R1 reset state");
    @(posedge clk); #2;

    step(1, 0, "R3 first tick from reset");
    step(0, 0, "R3 hold without tick");
    step(0, 0, "R3 hold second idle cycle");

    sp = 5; set_cal(7, 8, 9, 3, 4, 5, 2011); step(0, 0, "R2 load with spare bits");
    sp = 0;
    set_cal(59, 0, 0, 1, 1, 1, 2000); step(1, 0, "R2 load wins over tick");
    step(1, 0, "R3 minute carry");
    set_cal(59, 59, 12, 2, 3, 3, 2001); step(0, 0, "R2 load");
    step(1, 0, "R3 hour carry");
    set_cal(59, 59, 23, 7, 31, 12, 1999); step(0, 0, "R2 load");
    step(1, 0, "R4 R5 R7 new year 1999 weekday wrap");
    set_cal(59, 59, 23, 4, 30, 4, 2005); step(0, 0, "R2 load");
    step(1, 0, "R5 30-day month end");
    set_cal(59, 59, 23, 5, 30, 1, 2005); step(0, 0, "R2 load");
    step(1, 0, "R5 31-day month no wrap on 30");
    step(0, 0, "R3 hold");
    s = 59; mi = 59; h = 23; time_wdata_i = pack(); time_load_i = 1; step(0, 0, "R2 load");
    step(1, 0, "R5 31-day month end");
    set_cal(59, 59, 23, 1, 28, 2, 2000); step(0, 0, "R2 load");
    step(1, 0, "R6 2000 leap");
    s = 59; mi = 59; h = 23; time_wdata_i = pack(); time_load_i = 1; step(0, 0, "R2 load");
    step(1, 0, "R6 Feb 29 ends");
    set_cal(59, 59, 23, 4, 28, 2, 1900); step(0, 0, "R2 load");
    step(1, 0, "R6 1900 not leap");
    set_cal(59, 59, 23, 3, 28, 2, 2023); step(0, 0, "R2 load");
    step(1, 0, "R6 2023 not leap");
    set_cal(59, 59, 23, 4, 28, 2, 2024); step(0, 0, "R2 load");
    step(1, 0, "R6 2024 leap");
    set_cal(59, 59, 23, 5, 31, 12, 2099); step(0, 0, "R2 load");
    step(1, 0, "R7 century carry");
    set_cal(59, 59, 23, 6, 31, 12, 9999); step(0, 0, "R2 load");
    step(1, 0, "R7 9999 wraps");
    year_wdata_i = bcd(1987); yr = 1987; year_load_i = 1; step(1, 0, "R2 year load blocks tick");

    // Alarm
    set_cal(0, 0, 10, 4, 5, 1, 2000); step(0, 0, "R2 load");
    s = 1; m_time = pack()[28:0]; m_year = bcd(2001); s = 0;
    time_wdata_i = {3'b0, m_time}; year_wdata_i = m_year;
    match_time_load_i = 1; match_year_load_i = 1; step(0, 0, "R9 match load keeps time");
    step(1, 0, "R8 year mismatch no alarm");
    set_cal(0, 0, 10, 4, 5, 1, 2000); step(0, 0, "R2 load");
    m_year = bcd(2000); year_wdata_i = m_year; match_year_load_i = 1; step(0, 0, "R9 match year load");
    step(1, 0, "R8 alarm sets");
    step(1, 0, "R8 alarm sticky");
    step(0, 1, "R8 alarm clear");
    set_cal(0, 0, 10, 4, 5, 1, 2000); step(0, 0, "R2 load");
    step(1, 1, "R8 set beats clear");

    while (q_t.size() > 0) @(negedge clk);
    #1;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule